// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator and Interrupt Flag Register

This block decides when a real-time clock raises its interrupt. The time counter sits outside it. On every once-per-second update, a one-cycle strobe arrives together with the new seconds, minutes and hours bytes. The block holds three alarm bytes and compares them with the new time. When all three fields agree, it records an alarm event. Every update also records an update-ended event. A separate periodic tick input records a periodic event.

Each event has its own enable bit in a control register. The interrupt output is high while any recorded event has its enable set. Software reads the status register to collect the pending events, and that read clears them.

An alarm byte whose two top bits are both 1 matches any value of its field. In 12-hour mode the hour comparison includes the PM bit (bit 7). In 24-hour mode that bit takes no part. A small update-status register reports an update-in-progress indication. The indication is caught when the register is read while an update is approaching. It is then held for a fixed number of cycles and always drops when that count runs out, whatever is written to the alarm bytes meanwhile.

Register access is a plain single-cycle port with no back-pressure. An access is taken on the clock edge at which `bus_sel_i` is high, and read data is valid from the following cycle.

Top module: `alarm_flag_unit`

## Requirements
- R1: After reset the alarm bytes, control register and status flags are 0, `irq_o` is low and `bus_rdata_o` is 0.
- R2: An alarm byte with bits 7:6 equal to 2'b11 matches any value of its time field.
- R3: On an update strobe, the alarm flag (status bit 5) is set when every field matches. A field matches when it is equal to its time byte or is don't-care. The flag is not set when any field differs.
- R4: Every update strobe sets the update-ended flag (status bit 4). Every periodic tick sets the periodic flag (status bit 6).
- R5: A read of the status register (address 4) returns {any enabled flag set, periodic, alarm, update-ended, 4'b0000} and clears all flags. An event arriving in the same cycle as that read stays pending.
- R6: A set flag stays set until the status register is read.
- R7: `irq_o` is high exactly while a flag is set whose enable bit is set in the control register. Control bits 6, 5 and 4 enable the periodic, alarm and update-ended flags.
- R8: Control bit 1 selects 24-hour mode (1) or 12-hour mode (0). In 12-hour mode the hour comparison includes bit 7 (PM), so 2 AM (0x02) does not match 2 PM (0x82). In 24-hour mode bit 7 of the hour is ignored.
- R9: A read of address 5 returns bit 7 set when an update is approaching (`upd_soon_i`) or the held indication is active. Such a read with `upd_soon_i` high holds the indication for HOLD_CYCLES cycles. It then clears even if the alarm bytes are rewritten.
- R10: Addresses 0, 1 and 2 hold the seconds, minutes and hours alarm bytes and read back as written. Address 3 reads back only bits 6:4 and 1. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_tick_i | input | 1 | One-cycle strobe: the time bytes have just been updated |
| per_tick_i | input | 1 | One-cycle periodic event |
| upd_soon_i | input | 1 | An update will start within the hold window |
| now_sec_i | input | 8 | Current seconds byte |
| now_min_i | input | 8 | Current minutes byte |
| now_hour_i | input | 8 | Current hours byte (bit 7 = PM in 12-hour mode) |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the access |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
A wrong compare result shows as a wrong bit 5 in the first status read after the update strobe, one cycle after that strobe. A flag register that fails to clear or to hold shows as a wrong second read, or as `irq_o` staying high or dropping in the cycle right after the read edge. A stuck update-in-progress counter shows as bit 7 of address 5 still reading 1 more than HOLD_CYCLES cycles after it was caught.

// File: rtl/alarm_flag_pkg.sv
package alarm_flag_pkg;
  localparam int DW = 8;
  localparam int NF = 3;
  localparam int AW = 3;
  localparam int HOUR_IDX = 2;

  localparam logic [AW-1:0] ADR_SEC  = 3'd0;
  localparam logic [AW-1:0] ADR_MIN  = 3'd1;
  localparam logic [AW-1:0] ADR_HOUR = 3'd2;
  localparam logic [AW-1:0] ADR_CTRL = 3'd3;
  localparam logic [AW-1:0] ADR_STAT = 3'd4;
  localparam logic [AW-1:0] ADR_UPD  = 3'd5;

  // flag vector index: 0 update-ended, 1 alarm, 2 periodic
  localparam int FL_UPD = 0;
  localparam int FL_ALM = 1;
  localparam int FL_PER = 2;
  localparam int FL_N   = 3;

  typedef logic [NF-1:0][DW-1:0] field_vec_t;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_flag_pkg::*;
(
  input  field_vec_t alarm_i,
  input  field_vec_t now_i,
  input  logic       h24_i,
  output logic       hit_o
);
  logic [NF-1:0] ok;

  for (genvar f = 0; f < NF; f++) begin : g_field
    logic dont_care;
    assign dont_care = (alarm_i[f][DW-1:DW-2] == 2'b11);
    if (f == HOUR_IDX) begin : g_hour
      logic pm_ok;
      assign pm_ok = h24_i | (alarm_i[f][DW-1] == now_i[f][DW-1]);
      assign ok[f] = dont_care |
                     (pm_ok && (alarm_i[f][DW-2:0] == now_i[f][DW-2:0]));
    end else begin : g_plain
      assign ok[f] = dont_care | (alarm_i[f] == now_i[f]);
    end
  end

  assign hit_o = &ok;
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import alarm_flag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_tick_i,
  input  logic            per_tick_i,
  input  logic            alarm_hit_i,
  input  logic            clear_i,
  input  logic [FL_N-1:0] enable_i,
  output logic [FL_N-1:0] flags_o,
  output logic            irq_o
);
  logic [FL_N-1:0] set_v;

  always_comb begin
    set_v         = '0;
    set_v[FL_UPD] = upd_tick_i;
    set_v[FL_ALM] = upd_tick_i & alarm_hit_i;
    set_v[FL_PER] = per_tick_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= (clear_i ? '0 : flags_o) | set_v;
  end

  assign irq_o = |(flags_o & enable_i);
endmodule

// File: rtl/uip_hold.sv
module uip_hold #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (arm_i)        cnt_q <= CW'(HOLD_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/alarm_flag_unit.sv
module alarm_flag_unit
  import alarm_flag_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_tick_i,
  input  logic          per_tick_i,
  input  logic          upd_soon_i,
  input  logic [DW-1:0] now_sec_i,
  input  logic [DW-1:0] now_min_i,
  input  logic [DW-1:0] now_hour_i,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  field_vec_t      alarm_q;
  field_vec_t      now_v;
  logic [FL_N-1:0] irq_en_q;
  logic            hour24_q;
  logic [FL_N-1:0] flags;
  logic            alarm_hit;
  logic            uip_busy;
  logic            wr, rd, rd_stat, rd_upd;
  logic [DW-1:0]   rd_next;

  assign wr      = bus_sel_i & bus_we_i;
  assign rd      = bus_sel_i & ~bus_we_i;
  assign rd_stat = rd && (bus_addr_i == ADR_STAT);
  assign rd_upd  = rd && (bus_addr_i == ADR_UPD);
  assign now_v   = {now_hour_i, now_min_i, now_sec_i};

  for (genvar f = 0; f < NF; f++) begin : g_alarm_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                               alarm_q[f] <= '0;
      else if (wr && (bus_addr_i == AW'(f)))    alarm_q[f] <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en_q <= '0;
      hour24_q <= 1'b0;
    end else if (wr && (bus_addr_i == ADR_CTRL)) begin
      irq_en_q <= bus_wdata_i[6:4];
      hour24_q <= bus_wdata_i[1];
    end
  end

  alarm_match u_match (
    .alarm_i (alarm_q),
    .now_i   (now_v),
    .h24_i   (hour24_q),
    .hit_o   (alarm_hit)
  );

  flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_tick_i  (upd_tick_i),
    .per_tick_i  (per_tick_i),
    .alarm_hit_i (alarm_hit),
    .clear_i     (rd_stat),
    .enable_i    (irq_en_q),
    .flags_o     (flags),
    .irq_o       (irq_o)
  );

  uip_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_uip (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (rd_upd & upd_soon_i),
    .busy_o (uip_busy)
  );

  always_comb begin
    unique case (bus_addr_i)
      ADR_SEC:  rd_next = alarm_q[0];
      ADR_MIN:  rd_next = alarm_q[1];
      ADR_HOUR: rd_next = alarm_q[2];
      ADR_CTRL: rd_next = {1'b0, irq_en_q, 2'b00, hour24_q, 1'b0};
      ADR_STAT: rd_next = {irq_o, flags[FL_PER], flags[FL_ALM], flags[FL_UPD], 4'b0000};
      ADR_UPD:  rd_next = {uip_busy | upd_soon_i, 7'b0};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata_o <= '0;
    else if (rd) bus_rdata_o <= rd_next;
  end
endmodule

// File: rtl/alarm_flag_checker.sv
module alarm_flag_checker
  import alarm_flag_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            upd_tick,
  input logic            per_tick,
  input logic            rd_stat,
  input logic            uip_arm,
  input logic            uip_busy,
  input logic [FL_N-1:0] flags,
  input logic            irq,
  input field_vec_t      alarm
);
  logic [31:0] busy_run;
  logic        all_dc;

  assign all_dc = (alarm[0][7:6] == 2'b11) && (alarm[1][7:6] == 2'b11) &&
                  (alarm[2][7:6] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n)        busy_run <= '0;
    else if (uip_arm)  busy_run <= 32'd1;
    else if (uip_busy) busy_run <= busy_run + 1;
    else               busy_run <= '0;
  end

  p_readclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !upd_tick && !per_tick) |=> (flags == '0 && !irq));

  p_dontcare_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && all_dc) |=> flags[FL_ALM]);

  p_update_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |=> flags[FL_UPD]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((flags & $past(flags)) == $past(flags)));

  p_uip_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uip_busy |-> (busy_run <= HOLD_CYCLES));
endmodule

bind alarm_flag_unit alarm_flag_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd_tick (upd_tick_i),
  .per_tick (per_tick_i),
  .rd_stat  (rd_stat),
  .uip_arm  (rd_upd & upd_soon_i),
  .uip_busy (uip_busy),
  .flags    (flags),
  .irq      (irq_o),
  .alarm    (alarm_q)
);

// File: tb/alarm_flag_unit_test.sv
module alarm_flag_unit_test;
  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_tick = 1'b0, per_tick = 1'b0, upd_soon = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic       sel = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alarm_flag_unit #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .upd_tick_i(upd_tick), .per_tick_i(per_tick),
    .upd_soon_i(upd_soon), .now_sec_i(now_sec), .now_min_i(now_min),
    .now_hour_i(now_hour), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit fld_ok(input logic [7:0] al, input logic [7:0] cur,
                                input bit is_hour, input bit h24);
    if (al[7:6] == 2'b11) return 1'b1;
    if (is_hour && h24) return al[6:0] == cur[6:0];
    return al == cur;
  endfunction

  function automatic logic [7:0] stat_exp(input bit per, input bit alm, input bit upd,
                                          input logic [2:0] en);
    logic [2:0] f;
    f = {per, alm, upd};
    return {|(f & en), per, alm, upd, 4'b0000};
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic do_update(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    @(negedge clk); now_sec = s; now_min = m; now_hour = h; upd_tick = 1'b1;
    @(negedge clk); upd_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 rdata", int'(rdata), 0);
    bus_rd(3'd0, d); chk("R1 alarm sec", int'(d), 0);
    bus_rd(3'd3, d); chk("R1 control", int'(d), 0);
    bus_rd(3'd4, d); chk("R1 status", int'(d), 0);

    // R10 register map
    bus_wr(3'd0, 8'h12); bus_wr(3'd1, 8'h34); bus_wr(3'd2, 8'h86);
    bus_wr(3'd3, 8'hFF);
    bus_rd(3'd0, d); chk("R10 sec", int'(d), 'h12);
    bus_rd(3'd1, d); chk("R10 min", int'(d), 'h34);
    bus_rd(3'd2, d); chk("R10 hour", int'(d), 'h86);
    bus_rd(3'd3, d); chk("R10 control mask", int'(d), 'h72);
    bus_rd(3'd6, d); chk("R10 unused 6", int'(d), 0);
    bus_rd(3'd7, d); chk("R10 unused 7", int'(d), 0);

    // R8 12-hour: 2 PM alarm fires at 2 PM; 2 AM alarm does not
    bus_wr(3'd3, 8'h20);
    bus_wr(3'd0, 8'hC0); bus_wr(3'd1, 8'hC0); bus_wr(3'd2, 8'h82);
    do_update(8'h00, 8'h00, 8'h82);
    chk("R7 irq after alarm", int'(irq), 1);
    bus_rd(3'd4, d); chk("R8 pm alarm fires", int'(d), 'hB0);
    chk("R5 irq released", int'(irq), 0);
    bus_rd(3'd4, d); chk("R5 second read", int'(d), 0);
    bus_wr(3'd2, 8'h02);
    do_update(8'h00, 8'h00, 8'h82);
    chk("R7 no irq on am/pm mismatch", int'(irq), 0);
    bus_rd(3'd4, d); chk("R8 am alarm not at pm", int'(d), 'h10);
    // R8 24-hour: bit 7 ignored
    bus_wr(3'd3, 8'h22);
    do_update(8'h00, 8'h00, 8'h82);
    bus_rd(3'd4, d); chk("R8 24h ignores bit7", int'(d), 'hB0);

    // R4 periodic flag and R6 hold; R7 enable masking
    bus_wr(3'd3, 8'h10);
    @(negedge clk); per_tick = 1'b1; @(negedge clk); per_tick = 1'b0;
    chk("R7 periodic disabled no irq", int'(irq), 0);
    repeat (5) @(negedge clk);
    bus_rd(3'd4, d); chk("R4 R6 periodic pending", int'(d), 'h40);

    // R5 event coinciding with status read stays pending
    bus_wr(3'd3, 8'h00);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = 3'd4; upd_tick = 1'b1;
    now_sec = 8'h01; now_min = 8'h02; now_hour = 8'h03;
    @(negedge clk); sel = 1'b0; upd_tick = 1'b0;
    chk("R5 read before coinciding event", int'(rdata), 0);
    bus_rd(3'd4, d); chk("R5 coinciding event kept", int'(d), 'h10);

    // R9 update-in-progress hold and release
    bus_wr(3'd2, 8'h03);
    upd_soon = 1'b1;
    bus_rd(3'd5, d); chk("R9 uip latched", int'(d), 'h80);
    upd_soon = 1'b0;
    bus_rd(3'd5, d); chk("R9 uip held", int'(d), 'h80);
    bus_wr(3'd2, 8'h04);
    repeat (HOLD) @(negedge clk);
    bus_rd(3'd5, d); chk("R9 uip released", int'(d), 0);

    // Random mix: R2 R3 R7 R8
    for (int i = 0; i < 60; i++) begin
      logic [7:0] nw [3];
      logic [7:0] al [3];
      logic [2:0] en;
      bit h24, exp_alm;
      h24 = 1'($urandom % 2);
      en  = 3'($urandom % 8);
      nw[0] = 8'($urandom % 60);
      nw[1] = 8'($urandom % 60);
      nw[2] = 8'($urandom % 13) | ((($urandom % 2) == 1) ? 8'h80 : 8'h00);
      for (int f = 0; f < 3; f++) begin
        case ($urandom % 4)
          0: al[f] = nw[f];
          1: al[f] = 8'hC0 | 8'($urandom % 64);
          2: al[f] = 8'($urandom % 128);
          default: al[f] = nw[f] ^ 8'h80;
        endcase
        if ($urandom % 3 != 0 && al[f][7:6] != 2'b11) al[f] = nw[f];
      end
      exp_alm = fld_ok(al[0], nw[0], 0, h24) && fld_ok(al[1], nw[1], 0, h24) &&
                fld_ok(al[2], nw[2], 1, h24);
      bus_wr(3'd0, al[0]); bus_wr(3'd1, al[1]); bus_wr(3'd2, al[2]);
      bus_wr(3'd3, {1'b0, en, 2'b00, h24, 1'b0});
      do_update(nw[0], nw[1], nw[2]);
      chk("R7 irq random", int'(irq), int'(|({1'b0, exp_alm, 1'b1} & en)));
      bus_rd(3'd4, d);
      chk("R2 R3 status random", int'(d), int'(stat_exp(0, exp_alm, 1, en)));
    end

    done = 1'b1;
    finish_run();
  end
endmodule